// File: doc/BRIEF.md
# Start-Up Self-Test and Spare Configuration Controller

This controller manages a group of reconfigurable logic blocks. Each block holds several functional units and one spare, wired so that exactly one element at a time sits on a dedicated test port while the others carry live traffic. After every reset the controller walks the blocks through all their configurations. It keeps one fixed stimulus on the test input for the whole walk. In each configuration it compares each block's test response with a reference response.

The controller stops in the first configuration that shows a mismatch and stays there until the next reset. In that configuration the failing element is the one on the test port, so it is already out of service. No fault map is kept, because the walk runs again at each start-up. If every configuration passes, the controller returns to the normal configuration, where the spare is on the test port and all functional units are in service.

The configuration register is one-hot, so a single-bit upset breaks its parity. When that happens the controller reports the error and falls back to the normal configuration. One controller steps several blocks together.

Top module: `bisr_cfg_ctrl`

## Requirements
- R1: While reset is held, `cfg_sel` is 1 at bit 0 only, and `test_done`, `fault_flag` and `parity_err` are all 0. `test_vec` always equals the parameter `TEST_VEC`.
- R2: Bit i of `cfg_sel` places element i on the test port. Index 0 is the spare and is the normal configuration. Index i≥1 means unit i-1 is replaced by the shift onto the spare. After reset release the walk starts at index 0 and advances by one index every `DWELL` clocks.
- R3: Responses are compared only on the last clock of each `DWELL` window. A mismatch on any earlier clock of the window has no effect.
- R4: A mismatch sampled at index k stops the walk at index k and sets `test_done` at that same edge. `cfg_sel` then holds until reset. When several elements fail, the walk stops at the lowest failing index.
- R5: A mismatch on the response of any one of the `NUM_RLB` blocks stops all of them.
- R6: If no mismatch occurs, then after the last index has been sampled `cfg_sel` returns to index 0 and `test_done` rises. This happens `DWELL*(NUM_UNITS+1)` clocks after reset release.
- R7: `fault_flag` rises together with `test_done` only if the walk stopped at an index of 1 or more, which puts the spare in use. A failing spare (stop at index 0) leaves the flag at 0.
- R8: After `test_done`, the responses on the test port have no effect on `cfg_sel` or `fault_flag`.
- R9: A nonzero `seu_flip` toggles the matching configuration bits. On the next clock with even parity, `cfg_sel` returns to index 0, and `test_done` and `parity_err` become 1 while `fault_flag` becomes 0. `parity_err` stays set until reset.
- R10: A reset clears every result and starts a new walk from index 0. Nothing from the previous run is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts a walk when released |
| seu_flip | input | NUM_UNITS+1 | Upset injection: toggles configuration bits |
| ref_resp | input | RESP_W | Expected response to `test_vec` |
| test_resp | input | NUM_RLB*RESP_W | Test-port responses, block b at bits [b*RESP_W +: RESP_W] |
| test_vec | output | TEST_W | Fixed stimulus to every block's test input |
| cfg_sel | output | NUM_UNITS+1 | One-hot configuration index driving the block switches |
| fault_flag | output | 1 | Spare committed to functional use |
| test_done | output | 1 | Walk finished, stopped, or aborted by a parity error |
| parity_err | output | 1 | Configuration register upset detected |

## Verification
All results are registered. A compare window that fails shows its stop, `test_done` and `fault_flag` just after the edge that closes that window. That edge is `DWELL*(k+1)` edges after reset release for index k. A parity abort shows one edge after the edge that took the flip. The bench counts edges from the release, drives inputs and samples outputs on falling edges, and checks the exact edge count at which `test_done` first appears, with the index trace at every edge of a clean walk. For the ignore cases (a glitch early in a window, or bad responses after completion), the bench checks `cfg_sel` and the flags at the ports for several cycles.

// File: rtl/bisr_pkg.sv
package bisr_pkg;
    // Walk phase of the controller
    typedef enum logic {
        PH_WALK = 1'b0,
        PH_HOLD = 1'b1
    } phase_e;
endpackage

// File: rtl/bisr_resp_cmp.sv
// bisr_resp_cmp: compares every block's test-port response with the shared
// reference and ORs the results. Assumes responses are packed block by block.
module bisr_resp_cmp #(
    parameter int NUM_RLB = 2,
    parameter int RESP_W  = 4
) (
    input  logic [RESP_W-1:0]         ref_resp,
    input  logic [NUM_RLB*RESP_W-1:0] test_resp,
    output logic                      any_miss
);
    logic [NUM_RLB-1:0] miss;

    // one comparator per block
    for (genvar b = 0; b < NUM_RLB; b++) begin : g_blk
        assign miss[b] = (test_resp[b*RESP_W +: RESP_W] != ref_resp);
    end

    // any failing block stops the whole group
    assign any_miss = |miss;
endmodule

// File: rtl/bisr_dwell_timer.sv
// bisr_dwell_timer: counts DWELL clocks per configuration while the walk runs
// and flags the last clock of each window. Assumes DWELL >= 1.
module bisr_dwell_timer #(
    parameter int DWELL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(DWELL - 1);

    logic [CNT_W-1:0] cnt_q;

    // window counter, wraps on the last clock
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (run)      cnt_q <= (cnt_q == LAST_V) ? '0 : cnt_q + 1'b1;
    end

    assign last = (cnt_q == LAST_V);

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_V);
    assert_cnt_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && last) |=> (cnt_q == '0));
endmodule

// File: rtl/bisr_cfg_fsm.sv
// bisr_cfg_fsm: one-hot configuration register with walk, stop, hold and
// parity-abort behaviour. Assumes upsets are injected only through seu_flip.
module bisr_cfg_fsm #(
    parameter int NCFG = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCFG-1:0] seu_flip,
    input  logic            last,
    input  logic            miss,
    output logic [NCFG-1:0] cfg_q,
    output logic            running,
    output logic            spare_used,
    output logic            perr_q
);
    import bisr_pkg::*;

    localparam logic [NCFG-1:0] CFG_NORM = NCFG'(1);

    phase_e phase_q;
    logic   par_ok;
    logic   no_flip;

    // odd parity holds for any one-hot value
    assign par_ok  = ^cfg_q;
    assign no_flip = (seu_flip == '0);
    assign running = (phase_q == PH_WALK);

    // configuration walk, stop on mismatch, parity recovery
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= CFG_NORM;
            phase_q    <= PH_WALK;
            spare_used <= 1'b0;
            perr_q     <= 1'b0;
        end else if (!no_flip) begin
            cfg_q <= cfg_q ^ seu_flip;
        end else if (!par_ok) begin
            cfg_q      <= CFG_NORM;
            phase_q    <= PH_HOLD;
            spare_used <= 1'b0;
            perr_q     <= 1'b1;
        end else if (running && last) begin
            if (miss) begin
                phase_q    <= PH_HOLD;
                spare_used <= !cfg_q[0];
            end else if (cfg_q[NCFG-1]) begin
                cfg_q   <= CFG_NORM;
                phase_q <= PH_HOLD;
            end else begin
                cfg_q <= cfg_q << 1;
            end
        end
    end

    assert_mid_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && no_flip && par_ok && !last) |=> ($stable(cfg_q) && running));
    assert_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && no_flip && par_ok && last && miss) |=> ($stable(cfg_q) && !running));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && no_flip && par_ok) |=> ($stable(cfg_q) && $stable(spare_used) && !running));
    assert_recover_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (no_flip && !par_ok) |=> (perr_q && cfg_q == CFG_NORM && !spare_used));
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        perr_q |=> perr_q);
    assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seu_flip) == '0 && $past(par_ok)) |-> ($countones(cfg_q) == 1));
endmodule

// File: rtl/bisr_cfg_ctrl.sv
// bisr_cfg_ctrl: start-up self-test and spare configuration controller.
// It walks NUM_RLB blocks through NUM_UNITS+1 configurations with a fixed
// stimulus and stops at the first failing one. It assumes the block switches
// decode cfg_sel directly (bit 0 = spare on the test port, the normal state).
module bisr_cfg_ctrl #(
    parameter int                NUM_UNITS = 3,
    parameter int                NUM_RLB   = 2,
    parameter int                RESP_W    = 4,
    parameter int                TEST_W    = 4,
    parameter int                DWELL     = 2,
    parameter logic [TEST_W-1:0] TEST_VEC  = 'hA
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_UNITS:0]        seu_flip,
    input  logic [RESP_W-1:0]         ref_resp,
    input  logic [NUM_RLB*RESP_W-1:0] test_resp,
    output logic [TEST_W-1:0]         test_vec,
    output logic [NUM_UNITS:0]        cfg_sel,
    output logic                      fault_flag,
    output logic                      test_done,
    output logic                      parity_err
);
    localparam int NCFG = NUM_UNITS + 1;

    logic any_miss;
    logic last;
    logic running;

    // stimulus is fixed for the whole walk
    assign test_vec = TEST_VEC;

    bisr_resp_cmp #(.NUM_RLB(NUM_RLB), .RESP_W(RESP_W)) u_cmp (
        .ref_resp (ref_resp),
        .test_resp(test_resp),
        .any_miss (any_miss)
    );

    bisr_dwell_timer #(.DWELL(DWELL)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (running),
        .last (last)
    );

    bisr_cfg_fsm #(.NCFG(NCFG)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .seu_flip  (seu_flip),
        .last      (last),
        .miss      (any_miss),
        .cfg_q     (cfg_sel),
        .running   (running),
        .spare_used(fault_flag),
        .perr_q    (parity_err)
    );

    // done whenever the walk is no longer running
    assign test_done = !running;

    assert_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && $countones(cfg_sel) == 1) |-> (test_done && !cfg_sel[0]));
    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        test_done |=> test_done);
endmodule

// File: tb/sim_bisr_cfg_ctrl.sv
module sim_bisr_cfg_ctrl;
    localparam int NU  = 3;
    localparam int NC  = NU + 1;
    localparam int NB  = 2;
    localparam int RW  = 4;
    localparam int DW  = 2;
    localparam logic [3:0] TV = 4'h6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] seu_flip = '0;
    logic [RW-1:0] ref_resp = 4'h5;
    logic [NB*RW-1:0] test_resp;
    logic [3:0]    test_vec;
    logic [NC-1:0] cfg_sel;
    logic          fault_flag, test_done, parity_err;

    logic [NC-1:0] bad [NB];
    logic          glitch = 1'b0;
    logic          post   = 1'b0;
    int total = 0;
    int nbad  = 0;

    always #5 clk = ~clk;

    bisr_cfg_ctrl #(.NUM_UNITS(NU), .NUM_RLB(NB), .RESP_W(RW), .TEST_W(4),
                    .DWELL(DW), .TEST_VEC(TV)) u0 (
        .clk(clk), .rst_n(rst_n), .seu_flip(seu_flip), .ref_resp(ref_resp),
        .test_resp(test_resp), .test_vec(test_vec), .cfg_sel(cfg_sel),
        .fault_flag(fault_flag), .test_done(test_done), .parity_err(parity_err)
    );

    // behavioural model of the blocks: a faulty element on the test port corrupts the response
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            if (((bad[b] & cfg_sel) != '0) || (glitch && b == 0) || post)
                test_resp[b*RW +: RW] = ref_resp ^ 4'hF;
            else
                test_resp[b*RW +: RW] = ref_resp;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_run(input logic [NC-1:0] b0, input logic [NC-1:0] b1);
        @(negedge clk);
        rst_n = 1'b0; glitch = 1'b0; post = 1'b0; seu_flip = '0;
        bad[0] = b0; bad[1] = b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (cyc < 64) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (test_done) break;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(cfg_sel == 4'b0001, "R1 cfg_sel in reset", cfg_sel, 1);
        chk(!test_done && !fault_flag && !parity_err, "R1 flags in reset",
            {test_done, fault_flag, parity_err}, 0);
        chk(test_vec == TV, "R1 test_vec", test_vec, TV);
    endtask

    task automatic t_clean();
        int k;
        start_run('0, '0);
        chk(cfg_sel == 4'b0001, "R2 index at release", cfg_sel, 1);
        for (k = 1; k <= 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k < 8) begin
                chk(cfg_sel == NC'(1 << (k / 2)), "R2 walk index", cfg_sel, 1 << (k / 2));
                chk(!test_done, "R2 walking", test_done, 0);
            end
        end
        chk(test_done && cfg_sel == 4'b0001, "R6 clean return to normal", cfg_sel, 1);
        chk(!fault_flag, "R6 no fault flag", fault_flag, 0);
        chk(test_vec == TV, "R1 test_vec after walk", test_vec, TV);
    endtask

    task automatic t_glitch();
        int cyc;
        start_run('0, '0);
        glitch = 1'b1;
        cyc = 0;
        while (cyc < 64) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            glitch = (cyc % 2 == 0);
            if (test_done) break;
        end
        glitch = 1'b0;
        chk(cyc == 8, "R3 early-window glitch ignored (done edge)", cyc, 8);
        chk(cfg_sel == 4'b0001 && !fault_flag, "R3 no stop on glitch", cfg_sel, 1);
    endtask

    task automatic t_fault_unit();
        int cyc;
        start_run(4'b0100, '0);
        wait_done(cyc);
        chk(cyc == 6, "R4 stop edge at index 2", cyc, 6);
        chk(cfg_sel == 4'b0100, "R4 frozen index 2", cfg_sel, 4);
        chk(fault_flag, "R7 spare in use", fault_flag, 1);
        repeat (10) @(negedge clk);
        chk(cfg_sel == 4'b0100 && test_done, "R4 hold until reset", cfg_sel, 4);
    endtask

    task automatic t_two_faults();
        int cyc;
        start_run(4'b1010, '0);
        wait_done(cyc);
        chk(cyc == 4 && cfg_sel == 4'b0010, "R4 lowest failing index", cfg_sel, 2);
    endtask

    task automatic t_block1();
        int cyc;
        start_run('0, 4'b1000);
        wait_done(cyc);
        chk(cyc == 8, "R5 stop edge from block 1", cyc, 8);
        chk(cfg_sel == 4'b1000 && fault_flag, "R5 block 1 stops group", cfg_sel, 8);
    endtask

    task automatic t_spare_bad();
        int cyc;
        start_run(4'b0001, '0);
        wait_done(cyc);
        chk(cyc == 2 && cfg_sel == 4'b0001, "R7 spare fails at index 0", cfg_sel, 1);
        chk(!fault_flag, "R7 flag stays low for bad spare", fault_flag, 0);
    endtask

    task automatic t_after_done();
        int cyc;
        start_run('0, '0);
        wait_done(cyc);
        post = 1'b1;
        repeat (10) @(negedge clk);
        chk(cfg_sel == 4'b0001 && !fault_flag && test_done, "R8 responses ignored after done",
            cfg_sel, 1);
        post = 1'b0;
    endtask

    task automatic t_parity_walk();
        start_run('0, '0);
        repeat (3) begin @(posedge clk); @(negedge clk); end
        chk(cfg_sel == 4'b0010, "R2 index before upset", cfg_sel, 2);
        seu_flip = 4'b0100;
        @(posedge clk); @(negedge clk);
        seu_flip = '0;
        @(posedge clk); @(negedge clk);
        chk(cfg_sel == 4'b0001 && parity_err && test_done, "R9 recover to normal", cfg_sel, 1);
        chk(!fault_flag, "R9 flag cleared", fault_flag, 0);
        repeat (5) @(negedge clk);
        chk(parity_err && cfg_sel == 4'b0001, "R9 error sticky", parity_err, 1);
    endtask

    task automatic t_parity_frozen();
        int cyc;
        start_run(4'b0100, '0);
        wait_done(cyc);
        chk(fault_flag, "R7 flag before upset", fault_flag, 1);
        seu_flip = 4'b0100;
        @(posedge clk); @(negedge clk);
        seu_flip = '0;
        @(posedge clk); @(negedge clk);
        chk(cfg_sel == 4'b0001 && parity_err && !fault_flag, "R9 upset while frozen",
            cfg_sel, 1);
    endtask

    task automatic t_rerun();
        int cyc;
        start_run('0, 4'b0010);
        chk(!parity_err && !test_done && cfg_sel == 4'b0001, "R10 reset clears results",
            {parity_err, test_done}, 0);
        wait_done(cyc);
        chk(cyc == 4 && cfg_sel == 4'b0010 && fault_flag, "R10 fresh walk result", cfg_sel, 2);
    endtask

    initial begin
        #(200000 * 10);
        nbad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total + 1, nbad);
        $finish;
    end

    initial begin
        bad[0] = '0; bad[1] = '0;
        t_reset();
        t_clean();
        t_glitch();
        t_fault_unit();
        t_two_faults();
        t_block1();
        t_spare_bad();
        t_after_done();
        t_parity_walk();
        t_parity_frozen();
        t_rerun();
        $display("  test done: total=%0d bad=%0d", total, nbad);
        $finish;
    end
endmodule